// File: doc/BRIEF.md
# Accumulator Logic Execute Unit

This block is the execute stage of a small microcontroller core that uses 12-bit instruction words. It keeps an 8-bit working register (W), a zero flag and a 32 x 8-bit file of data registers. Each cycle in which the valid input is high, it decodes one instruction word and retires it in that same cycle. The result appears on the outputs after the next rising clock edge.

Four operations are recognised: OR of W with an immediate, loading an immediate into W, OR of W with a file register, and moving a file register. The two register forms carry a destination bit. It sends the result either to W or back to the addressed register. Every other word does nothing. A debug port lets a test environment write any file register and read any file register combinationally. Its write takes precedence over an instruction write to the same address.

Top module: `acc_logic_exec`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, W, the zero flag and all 32 file registers become 0x00 / 0.
- R2: A valid word with bits [11:8] = 4'b1101 sets W to W OR k, where k = bits [7:0], and leaves the file registers unchanged.
- R3: A valid word with bits [11:8] = 4'b1100 sets W to k (bits [7:0]) and leaves the zero flag and the file registers unchanged.
- R4: A valid word with bits [11:6] = 6'b000100 computes W OR reg[f], where f = bits [4:0] and d = bit 5. When d = 0 the result goes to W and reg[f] is unchanged. When d = 1 the result goes to reg[f] and W is unchanged.
- R5: A valid word with bits [11:6] = 6'b001000 copies reg[f] to W when d = 0, or writes reg[f] back unchanged when d = 1. W is unchanged in the second case.
- R6: After the immediate OR, the register OR and the register move, the zero flag is 1 exactly when the 8-bit result is 0x00. This includes the move with d = 1.
- R7: A word that matches none of the four patterns, or any word presented with `instr_valid` low, leaves W, the zero flag and every file register unchanged.
- R8: When a debug write and an instruction write target the same register in one cycle, the debug data is stored. When they target different registers, both writes take effect.
- R9: `dbg_rdata` shows reg[`dbg_raddr`] combinationally, including a write made at the most recent clock edge.
- R10: Each instruction takes effect at the first rising edge at which it is valid, so one new word can be applied every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 12 | Instruction word |
| dbg_we | input | 1 | Debug write enable |
| dbg_waddr | input | 5 | Debug write address |
| dbg_wdata | input | 8 | Debug write data |
| dbg_raddr | input | 5 | Debug read address |
| dbg_rdata | output | 8 | Debug read data (combinational) |
| w_out | output | 8 | Working register W |
| zero_out | output | 1 | Zero flag |

## Verification
The bench runs all 4096 instruction words in sequence against a model built from the requirements. After each word it compares W, the flag and the addressed register. It also sweeps a grid of W and immediate values through the immediate OR.

It targets the following corner cases, each with the symptom a broken design would show:
- Load-immediate after a zero result: a design that wrongly updates the flag on a load would clear it.
- Move with d = 1 over zero and non-zero registers: a design that skips the flag on a write-back would leave it stale.
- Near-miss encodings such as 0001 01xx xxxx: a loose decoder would execute them instead of ignoring them.
- Simultaneous debug and instruction writes to one address: a design with the wrong priority would keep the instruction result instead of the debug data.

// File: rtl/acc_exec_pkg.sv
// Package: acc_exec_pkg
// Shared widths, opcode patterns and the decoded-instruction type for the
// accumulator logic execute unit. Assumes a fixed 12-bit instruction format.
package acc_exec_pkg;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 5;
    localparam int INSTR_W = 12;

    // Opcode patterns: literal forms decode bits [11:8], register forms [11:6]
    localparam logic [3:0] PAT_OR_IMM  = 4'b1101;
    localparam logic [3:0] PAT_LD_IMM  = 4'b1100;
    localparam logic [5:0] PAT_OR_REG  = 6'b000100;
    localparam logic [5:0] PAT_MOV_REG = 6'b001000;

    typedef enum logic [2:0] {
        OP_NOP,
        OP_OR_IMM,
        OP_LD_IMM,
        OP_OR_REG,
        OP_MOV_REG
    } op_e;

    typedef struct packed {
        op_e               op;
        logic              to_file;
        logic [ADDR_W-1:0] faddr;
        logic [DATA_W-1:0] imm;
    } dec_t;
endpackage

// File: rtl/acc_decoder.sv
// Module: acc_decoder
// Purely combinational decode of one instruction word into an operation,
// destination bit, register address and immediate. Words that match no
// pattern decode to OP_NOP. Assumes the caller qualifies with a valid bit.
module acc_decoder
    import acc_exec_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    // Match the opcode patterns and pick out the operand fields
    always_comb begin
        dec.op      = OP_NOP;
        dec.to_file = instr[ADDR_W];
        dec.faddr   = instr[ADDR_W-1:0];
        dec.imm     = instr[DATA_W-1:0];
        if (instr[INSTR_W-1 -: 4] == PAT_OR_IMM) begin
            dec.op = OP_OR_IMM;
        end else if (instr[INSTR_W-1 -: 4] == PAT_LD_IMM) begin
            dec.op = OP_LD_IMM;
        end else if (instr[INSTR_W-1 -: 6] == PAT_OR_REG) begin
            dec.op = OP_OR_REG;
        end else if (instr[INSTR_W-1 -: 6] == PAT_MOV_REG) begin
            dec.op = OP_MOV_REG;
        end
    end
endmodule

// File: rtl/acc_regfile.sv
// Module: acc_regfile
// Flop-based register file with one execute write port, one debug write
// port, a combinational execute read port and a combinational debug read
// port. The debug write overrides an execute write to the same entry.
// Assumes a synchronous active-low reset that clears every entry.
module acc_regfile #(
    parameter int DW    = 8,
    parameter int AW    = 5,
    parameter int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ex_we,
    input  logic [AW-1:0] ex_waddr,
    input  logic [DW-1:0] ex_wdata,
    input  logic [AW-1:0] ex_raddr,
    output logic [DW-1:0] ex_rdata,
    input  logic          dbg_we,
    input  logic [AW-1:0] dbg_waddr,
    input  logic [DW-1:0] dbg_wdata,
    input  logic [AW-1:0] dbg_raddr,
    output logic [DW-1:0] dbg_rdata
);
    logic [DW-1:0] mem [DEPTH];

    // Store writes; the debug write comes last so that it wins on a collision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else begin
            if (ex_we) begin
                mem[ex_waddr] <= ex_wdata;
            end
            if (dbg_we) begin
                mem[dbg_waddr] <= dbg_wdata;
            end
        end
    end

    // Combinational read ports
    assign ex_rdata  = mem[ex_raddr];
    assign dbg_rdata = mem[dbg_raddr];

    // R8: a colliding debug write must leave its own data in the entry
    p_dbg_priority_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_we && ex_we && dbg_waddr == ex_waddr)
        |=> mem[$past(dbg_waddr)] == $past(dbg_wdata));

    // R8: an execute write to a different entry still lands
    p_ex_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_we && !(dbg_we && dbg_waddr == ex_waddr))
        |=> mem[$past(ex_waddr)] == $past(ex_wdata));
endmodule

// File: rtl/acc_datapath.sv
// Module: acc_datapath
// Computes the result for the decoded operation, holds W and the zero
// flag, and drives the register-file write port for file destinations.
// Assumes the file read data belongs to dec.faddr in the same cycle.
module acc_datapath
    import acc_exec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  dec_t              dec,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic              rf_we,
    output logic [ADDR_W-1:0] rf_waddr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic [DATA_W-1:0] w_q,
    output logic              z_q
);
    logic [DATA_W-1:0] result;
    logic              sets_z;
    logic              reg_form;
    logic              w_we;

    // Select the result and which state elements it updates
    always_comb begin
        result   = '0;
        sets_z   = 1'b0;
        reg_form = 1'b0;
        unique case (dec.op)
            OP_OR_IMM:  begin result = w_q | dec.imm;    sets_z = 1'b1; end
            OP_LD_IMM:  begin result = dec.imm;                         end
            OP_OR_REG:  begin result = w_q | rf_rdata;   sets_z = 1'b1; reg_form = 1'b1; end
            OP_MOV_REG: begin result = rf_rdata;         sets_z = 1'b1; reg_form = 1'b1; end
            default:    begin result = '0;                              end
        endcase
        w_we  = valid && (dec.op == OP_OR_IMM || dec.op == OP_LD_IMM ||
                          (reg_form && !dec.to_file));
        rf_we = valid && reg_form && dec.to_file;
    end

    assign rf_waddr = dec.faddr;
    assign rf_wdata = result;

    // Hold the working register and the zero flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q <= '0;
            z_q <= 1'b0;
        end else begin
            if (w_we) begin
                w_q <= result;
            end
            if (valid && sets_z) begin
                z_q <= (result == '0);
            end
        end
    end

    // R2: immediate OR folds the literal into W
    p_or_imm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && dec.op == OP_OR_IMM) |=> w_q == ($past(w_q) | $past(dec.imm)));

    // R3: immediate load leaves the zero flag alone
    p_ld_keeps_z_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && dec.op == OP_LD_IMM) |=> $stable(z_q));

    // R4 and R5: a file-destination write leaves W alone
    p_file_dest_keeps_w_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> $stable(w_q));

    // R6: when a flag-setting op writes W, the flag reflects the new W
    p_zero_matches_w_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && sets_z && !rf_we) |=> z_q == (w_q == '0));

    // R7: idle or unmatched words change neither W nor the flag
    p_nop_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid || dec.op == OP_NOP) |=> ($stable(w_q) && $stable(z_q)));

    // R7: no file write without a valid register-form word
    p_no_stray_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid || dec.op == OP_NOP) |-> !rf_we);
endmodule

// File: rtl/acc_logic_exec.sv
// Module: acc_logic_exec
// Top of the accumulator logic execute unit: decoder, datapath (W and the
// zero flag) and the register file with its debug ports. Retires one valid
// instruction per cycle. Synchronous active-low reset clears all state.
module acc_logic_exec
    import acc_exec_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic               dbg_we,
    input  logic [ADDR_W-1:0]  dbg_waddr,
    input  logic [DATA_W-1:0]  dbg_wdata,
    input  logic [ADDR_W-1:0]  dbg_raddr,
    output logic [DATA_W-1:0]  dbg_rdata,
    output logic [DATA_W-1:0]  w_out,
    output logic               zero_out
);
    dec_t              dec;
    logic [DATA_W-1:0] rf_rdata;
    logic              rf_we;
    logic [ADDR_W-1:0] rf_waddr;
    logic [DATA_W-1:0] rf_wdata;

    acc_decoder u_dec (
        .instr (instr),
        .dec   (dec)
    );

    acc_datapath u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (instr_valid),
        .dec      (dec),
        .rf_rdata (rf_rdata),
        .rf_we    (rf_we),
        .rf_waddr (rf_waddr),
        .rf_wdata (rf_wdata),
        .w_q      (w_out),
        .z_q      (zero_out)
    );

    acc_regfile #(
        .DW (DATA_W),
        .AW (ADDR_W)
    ) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .ex_we     (rf_we),
        .ex_waddr  (rf_waddr),
        .ex_wdata  (rf_wdata),
        .ex_raddr  (dec.faddr),
        .ex_rdata  (rf_rdata),
        .dbg_we    (dbg_we),
        .dbg_waddr (dbg_waddr),
        .dbg_wdata (dbg_wdata),
        .dbg_raddr (dbg_raddr),
        .dbg_rdata (dbg_rdata)
    );

    // R1: the cycle after a reset edge, W and the flag are clear
    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (w_out == '0 && zero_out == 1'b0));
endmodule

// File: tb/acc_logic_exec_test.sv
module acc_logic_exec_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [11:0] instr = '0;
    logic        dbg_we = 1'b0;
    logic [4:0]  dbg_waddr = '0;
    logic [7:0]  dbg_wdata = '0;
    logic [4:0]  dbg_raddr = '0;
    logic [7:0]  dbg_rdata;
    logic [7:0]  w_out;
    logic        zero_out;

    int n_chk = 0;
    int n_err = 0;

    logic [7:0] m_w;
    logic       m_z;
    logic [7:0] m_rf [32];

    always #5 clk = ~clk;

    acc_logic_exec uut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .dbg_we(dbg_we), .dbg_waddr(dbg_waddr), .dbg_wdata(dbg_wdata),
        .dbg_raddr(dbg_raddr), .dbg_rdata(dbg_rdata),
        .w_out(w_out), .zero_out(zero_out)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd_reg(input logic [4:0] a, output logic [7:0] v);
        dbg_raddr = a;
        #1;
        v = dbg_rdata;
    endtask

    task automatic dbg_write(input logic [4:0] a, input logic [7:0] d);
        dbg_we = 1'b1; dbg_waddr = a; dbg_wdata = d;
        @(posedge clk); #2;
        dbg_we = 1'b0;
        m_rf[a] = d;
    endtask

    // Reference behaviour from the requirements; returns the requirement tag
    task automatic model(input logic [11:0] iw, output string tag);
        logic [7:0] k, r;
        logic [4:0] f;
        logic       d;
        k = iw[7:0]; f = iw[4:0]; d = iw[5];
        if (iw[11:8] == 4'b1101) begin
            m_w = m_w | k; m_z = (m_w == 8'h00); tag = "R2";
        end else if (iw[11:8] == 4'b1100) begin
            m_w = k; tag = "R3";
        end else if (iw[11:6] == 6'b000100) begin
            r = m_w | m_rf[f]; m_z = (r == 8'h00);
            if (d) m_rf[f] = r; else m_w = r;
            tag = "R4";
        end else if (iw[11:6] == 6'b001000) begin
            r = m_rf[f]; m_z = (r == 8'h00);
            if (!d) m_w = r;
            tag = "R5";
        end else begin
            tag = "R7";
        end
    endtask

    // Apply one valid word for one cycle, then compare W, flag and reg[f]
    task automatic exec(input logic [11:0] iw);
        string tag;
        logic [7:0] v;
        instr = iw; instr_valid = 1'b1;
        @(posedge clk); #2;
        instr_valid = 1'b0; instr = '0;
        model(iw, tag);
        chk({tag, " W (R10 single cycle)"}, w_out, m_w);
        chk({tag, " zero flag (R6)"}, {7'b0, zero_out}, {7'b0, m_z});
        rd_reg(iw[4:0], v);
        chk({tag, " file reg"}, v, m_rf[iw[4:0]]);
    endtask

    task automatic check_all_regs(input string tag);
        logic [7:0] v;
        for (int a = 0; a < 32; a++) begin
            rd_reg(a[4:0], v);
            chk(tag, v, m_rf[a]);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk); @(posedge clk); #2;
        rst_n = 1'b1;
        m_w = '0; m_z = 1'b0;
        for (int a = 0; a < 32; a++) m_rf[a] = '0;
    endtask

    initial begin
        #2_000_000;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [7:0] v;
        // R1: reset state
        do_reset();
        chk("R1 W after reset", w_out, 8'h00);
        chk("R1 zero after reset", {7'b0, zero_out}, 8'h00);
        check_all_regs("R1 file after reset");

        // R9: debug write visible right after the edge, reads combinational
        for (int a = 0; a < 32; a++) dbg_write(a[4:0], 8'(a * 37 + 5));
        check_all_regs("R9 debug readback");

        // R2 example and R4 example
        exec(12'hC9A); exec(12'hD35);
        chk("R2 example W", w_out, 8'hBF);
        dbg_write(5'd3, 8'h13);
        exec(12'hC91); exec({6'b000100, 1'b0, 5'd3});
        chk("R4 example W", w_out, 8'h93);
        rd_reg(5'd3, v); chk("R4 example reg", v, 8'h13);

        // R3: load after a zero result keeps the flag set
        exec(12'hC00); exec(12'hD00);
        chk("R6 zero set", {7'b0, zero_out}, 8'h01);
        exec(12'hC55);
        chk("R3 flag kept", {7'b0, zero_out}, 8'h01);

        // R5/R6: move with d=1 as zero test
        dbg_write(5'd9, 8'h00);
        exec({6'b001000, 1'b1, 5'd9});
        chk("R5 test zero reg", {7'b0, zero_out}, 8'h01);
        chk("R5 W kept", w_out, 8'h55);
        dbg_write(5'd10, 8'h80);
        exec({6'b001000, 1'b1, 5'd10});
        chk("R5 test nonzero reg", {7'b0, zero_out}, 8'h00);

        // R2/R6: grid of W and literal values
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                exec({4'b1100, 8'(a * 17)});
                exec({4'b1101, 8'(b * 17)});
            end
        end

        // R7: idle cycles with garbage on the word change nothing
        instr = 12'hD00; instr_valid = 1'b0;
        @(posedge clk); #2;
        chk("R7 idle W", w_out, m_w);
        instr = '0;

        // R4..R7, R10: every instruction word back to back
        for (int i = 0; i < 4096; i++) begin
            exec(12'(i));
            if (i % 256 == 255) exec(12'(12'hC00 + ((i >> 8) * 29)));
        end
        check_all_regs("R7 file after sweep");

        // R8: collision with an instruction file write, debug wins
        exec(12'hC0F);
        dbg_write(5'd7, 8'h30);
        instr = {6'b000100, 1'b1, 5'd7}; instr_valid = 1'b1;
        dbg_we = 1'b1; dbg_waddr = 5'd7; dbg_wdata = 8'hC3;
        @(posedge clk); #2;
        instr_valid = 1'b0; dbg_we = 1'b0;
        rd_reg(5'd7, v); chk("R8 debug wins", v, 8'hC3);
        chk("R8 W kept", w_out, 8'h0F);
        // R8: different addresses, both land
        instr = {6'b000100, 1'b1, 5'd11}; instr_valid = 1'b1;
        dbg_we = 1'b1; dbg_waddr = 5'd12; dbg_wdata = 8'h5A;
        dbg_write(5'd11, 8'h40);
        instr_valid = 1'b0;
        dbg_write(5'd11, 8'h40);
        instr = {6'b000100, 1'b1, 5'd11}; instr_valid = 1'b1;
        dbg_we = 1'b1; dbg_waddr = 5'd12; dbg_wdata = 8'h5A;
        @(posedge clk); #2;
        instr_valid = 1'b0; dbg_we = 1'b0;
        rd_reg(5'd11, v); chk("R8 instr write lands", v, 8'h4F);
        rd_reg(5'd12, v); chk("R8 debug write lands", v, 8'h5A);

        // R1: reset mid-run clears everything
        do_reset();
        chk("R1 W after second reset", w_out, 8'h00);
        chk("R1 zero after second reset", {7'b0, zero_out}, 8'h00);
        check_all_regs("R1 file after second reset");

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule